// File: doc/BRIEF.md
# Half-integer clock divider

This block derives a slower clock from a source clock by one of eight ratios: 1.5, 2, 2.5, 3, 4, 5, 8 or 16. It runs on a sample clock at twice the source rate, so one sample cycle covers one half-period of the source. Each output period lasts 2N sample cycles for ratio N. Odd counts such as 3 or 5 cannot give an exact 50/50 split at that resolution, so the output is a two-slot level vector. Each sample cycle reports the divided clock's level in its first and second half. Downstream logic can serialise the pair or treat it as a quarter-period-accurate waveform.

In normal mode the high portion is exactly half of each output period for every ratio. A high-frequency mode changes only the two non-integer ratios: the output is high for one third of the period at 1.5 and for two fifths of the period at 2.5. The divider stays idle with its output low until a lock-qualified enable is raised. A new ratio or mode is picked up only at the start of an output period.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While the synchronous reset is high, the output reads 2'b00 one cycle later. The first period after reset starts at phase 0.
- R2: While the lock enable is low, the output reads 2'b00 from the next cycle on and the phase counter is cleared. After the enable returns, output begins again with phase 0 of a period.
- R3: The select code sets the period length in sample cycles: code 0→3, 1→4, 2→5, 3→6, 4→8, 5→10, 6→16, 7→32. These are ratios 1.5, 2, 2.5, 3, 4, 5, 8 and 16.
- R4: In normal mode (mode bit 0), the output is high for exactly P of the 2P half-sample slots of every period.
- R5: In high-frequency mode (mode bit 1) with code 0, the output is high for 2 of 6 slots, one third of the period.
- R6: In high-frequency mode with code 2, the output is high for 4 of 10 slots, two fifths of the period.
- R7: The mode bit has no effect for codes 1 and 3 to 7.
- R8: A change of the select code or of the mode bit while running takes effect only at the next phase 0. The period already in progress completes with its old settings.
- R9: The output encoding is fixed. Bit 0 is the level in the first half of a sample cycle and bit 1 the level in the second half. Slot index 2·phase+bit is high exactly when it is below the high count. So the output rises only at a period start, and mid-cycle falls show as 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Sample clock at twice the source rate |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 3 | Divide ratio code (see R3) |
| hf_mode | input | 1 | High-frequency duty mode for ratios 1.5 and 2.5 |
| lock_en | input | 1 | Lock-qualified run enable |
| div_lvl | output | 2 | Divided clock level, first-half slot in bit 0, second-half slot in bit 1 |

## Verification
The hardest situation to create from the ports is a settings change in the middle of a period. The bench has to know the exact phase in order to tell the old settings from the new ones. The stimulus enables the divider from a cleared state, counts sample cycles from that point, and changes the code or the mode bit just after a chosen phase. It then expects the old pattern up to the wrap and the new pattern afterwards. A mode-only change at ratio 1.5 is included because it alters a single slot value in the next period.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

  typedef enum logic [2:0] {
    DIV_1P5 = 3'd0,
    DIV_2   = 3'd1,
    DIV_2P5 = 3'd2,
    DIV_3   = 3'd3,
    DIV_4   = 3'd4,
    DIV_5   = 3'd5,
    DIV_8   = 3'd6,
    DIV_16  = 3'd7
  } ratio_e;

  // Output period length in sample cycles (source half-periods).
  function automatic int unsigned period_cycles(ratio_e r);
    case (r)
      DIV_1P5: return 3;
      DIV_2:   return 4;
      DIV_2P5: return 5;
      DIV_3:   return 6;
      DIV_4:   return 8;
      DIV_5:   return 10;
      DIV_8:   return 16;
      default: return 32;
    endcase
  endfunction

  // High time in half-sample slots; a period has 2*period_cycles slots.
  function automatic int unsigned high_slots(ratio_e r, logic hf);
    if (hf && r == DIV_1P5) return 2;
    if (hf && r == DIV_2P5) return 4;
    return period_cycles(r);
  endfunction

endpackage

// File: rtl/hdiv_ratio_decode.sv
`timescale 1ns/1ps
module hdiv_ratio_decode
  import hdiv_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SEL_W = 3,
  localparam int SLOT_W = CNT_W + 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              hf,
  output logic [CNT_W-1:0]  last_phase,
  output logic [SLOT_W-1:0] high_cnt
);

  ratio_e r;

  always_comb begin
    r          = ratio_e'(sel);
    last_phase = CNT_W'(period_cycles(r) - 1);
    high_cnt   = SLOT_W'(high_slots(r, hf));
  end

endmodule

// File: rtl/hdiv_cfg_hold.sv
`timescale 1ns/1ps
module hdiv_cfg_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         at_start,
  input  logic [W-1:0] live,
  output logic [W-1:0] eff
);

  logic [W-1:0] held;

  // Live settings steer phase 0; later phases reuse the captured copy.
  assign eff = at_start ? live : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (run && at_start) begin
      held <= live;
    end
  end

endmodule

// File: rtl/hdiv_phase_ctr.sv
`timescale 1ns/1ps
module hdiv_phase_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] last_phase,
  output logic [CNT_W-1:0] phase,
  output logic             at_start
);

  assign at_start = (phase == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == last_phase) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/hdiv_duty_shaper.sv
`timescale 1ns/1ps
module hdiv_duty_shaper #(
  parameter int CNT_W = 5,
  parameter int SLOTS = 2,
  localparam int SLOT_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CNT_W-1:0]  phase,
  input  logic [SLOT_W-1:0] high_cnt,
  output logic [SLOTS-1:0]  lvl
);

  logic [SLOTS-1:0] lvl_nxt;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] idx;
    assign idx        = {phase, 1'b0} + SLOT_W'(s);
    assign lvl_nxt[s] = run && (idx < high_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
    end else begin
      lvl <= lvl_nxt;
    end
  end

endmodule

// File: rtl/halfstep_clkdiv.sv
`timescale 1ns/1ps
module halfstep_clkdiv #(
  parameter int CNT_W = 5,
  parameter int SEL_W = 3,
  localparam int SLOT_W = CNT_W + 1,
  localparam int CFG_W  = SEL_W + 1
) (
  input  logic             clk_2x,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             hf_mode,
  input  logic             lock_en,
  output logic [1:0]       div_lvl
);

  logic [CNT_W-1:0]  phase;
  logic              at_start;
  logic [CFG_W-1:0]  cfg_eff;
  logic [CNT_W-1:0]  last_phase;
  logic [SLOT_W-1:0] high_cnt;

  hdiv_cfg_hold #(.W(CFG_W)) u_hold (
    .clk      (clk_2x),
    .rst      (rst),
    .run      (lock_en),
    .at_start (at_start),
    .live     ({hf_mode, ratio_sel}),
    .eff      (cfg_eff)
  );

  hdiv_ratio_decode #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dec (
    .sel        (cfg_eff[SEL_W-1:0]),
    .hf         (cfg_eff[SEL_W]),
    .last_phase (last_phase),
    .high_cnt   (high_cnt)
  );

  hdiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk_2x),
    .rst        (rst),
    .run        (lock_en),
    .last_phase (last_phase),
    .phase      (phase),
    .at_start   (at_start)
  );

  hdiv_duty_shaper #(.CNT_W(CNT_W), .SLOTS(2)) u_shape (
    .clk      (clk_2x),
    .rst      (rst),
    .run      (lock_en),
    .phase    (phase),
    .high_cnt (high_cnt),
    .lvl      (div_lvl)
  );

endmodule

// File: rtl/hdiv_checker.sv
`timescale 1ns/1ps
module hdiv_checker (
  input logic       clk,
  input logic       rst,
  input logic       lock_en,
  input logic [1:0] lvl
);

  logic       rst_q;
  logic [1:0] lvl_q;
  logic       seen;
  logic [5:0] since;
  logic       rise;

  assign rise = lvl[0] && !lvl_q[1];

  function automatic logic legal_len(logic [5:0] n);
    return n == 6'd3 || n == 6'd4 || n == 6'd5 || n == 6'd6 ||
           n == 6'd8 || n == 6'd10 || n == 6'd16 || n == 6'd32;
  endfunction

  always_ff @(posedge clk) begin
    rst_q <= rst;
    lvl_q <= lvl;
    if (rst_q) begin
      assert_reset_low_R1: assert (lvl == 2'b00)
        else $error("output not low after reset");
    end
    if (!rst && lock_en && rise && seen) begin
      assert_period_legal_R3: assert (legal_len(since))
        else $error("illegal period length %0d", since);
    end
    if (rst || !lock_en) begin
      seen  <= 1'b0;
      since <= '0;
    end else if (rise) begin
      seen  <= 1'b1;
      since <= 6'd1;
    end else if (since != 6'h3f) begin
      since <= since + 1'b1;
    end
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> (lvl == 2'b00));

  assert_no_mid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    lvl != 2'b10);

endmodule

bind halfstep_clkdiv hdiv_checker u_chk (
  .clk     (clk_2x),
  .rst     (rst),
  .lock_en (lock_en),
  .lvl     (div_lvl)
);

// File: tb/sim_halfstep_clkdiv.sv
`timescale 1ns/1ps
module sim_halfstep_clkdiv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_sel = 3'd0;
  logic       hf_mode = 1'b0;
  logic       lock_en = 1'b0;
  logic [1:0] div_lvl;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  halfstep_clkdiv u0 (
    .clk_2x    (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .hf_mode   (hf_mode),
    .lock_en   (lock_en),
    .div_lvl   (div_lvl)
  );

  function automatic int per_len(int s);
    case (s)
      0: return 3;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 8;
      5: return 10;
      6: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int hi_slots(int s, int h);
    if (h != 0 && s == 0) return 2;
    if (h != 0 && s == 2) return 4;
    return per_len(s);
  endfunction

  function automatic logic [1:0] exp_lvl(int s, int h, int ph);
    logic [1:0] v;
    for (int b = 0; b < 2; b++) v[b] = ((2 * ph + b) < hi_slots(s, h));
    return v;
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: div_lvl=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step_chk(input int s, input int h, input int ph, input string tag);
    tick();
    chk(div_lvl, exp_lvl(s, h, ph), tag);
  endtask

  task automatic idle_then(input int s, input int h);
    lock_en   = 1'b0;
    ratio_sel = 3'(s);
    hf_mode   = h[0];
    tick();
    chk(div_lvl, 2'b00, "R2");
    lock_en = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick();
    chk(div_lvl, 2'b00, "R1");
    rst = 1'b0;
    tick();
    chk(div_lvl, 2'b00, "R2");

    // Sweep every code in both modes for three periods each.
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < 8; s++) begin
        int p;
        p = per_len(s);
        idle_then(s, h);
        for (int k = 0; k < 3 * p; k++) begin
          string tag;
          int ph;
          ph = k % p;
          if (ph == 0) tag = "R3";
          else if (exp_lvl(s, h, ph) == 2'b01) tag = "R9";
          else if (h != 0 && s == 0) tag = "R5";
          else if (h != 0 && s == 2) tag = "R6";
          else if (h != 0) tag = "R7";
          else tag = "R4";
          step_chk(s, h, ph, tag);
        end
      end
    end

    // Reset in the middle of a period.
    idle_then(3, 0);
    for (int ph = 0; ph < 3; ph++) step_chk(3, 0, ph, "R4");
    rst = 1'b1;
    tick();
    chk(div_lvl, 2'b00, "R1");
    tick();
    chk(div_lvl, 2'b00, "R1");
    rst = 1'b0;
    step_chk(3, 0, 0, "R1");
    step_chk(3, 0, 1, "R1");

    // Lock enable removed in the middle of a period.
    idle_then(5, 0);
    for (int ph = 0; ph < 4; ph++) step_chk(5, 0, ph, "R4");
    lock_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(div_lvl, 2'b00, "R2");
    end
    lock_en = 1'b1;
    for (int ph = 0; ph < 10; ph++) step_chk(5, 0, ph, "R2");

    // Code change mid-period: old period completes first.
    idle_then(2, 0);
    step_chk(2, 0, 0, "R8");
    ratio_sel = 3'd7;
    hf_mode   = 1'b1;
    for (int ph = 1; ph < 5; ph++) step_chk(2, 0, ph, "R8");
    for (int k = 0; k < 64; k++) step_chk(7, 1, k % 32, "R8");

    // Mode-only change at ratio 1.5.
    idle_then(0, 0);
    step_chk(0, 0, 0, "R8");
    hf_mode = 1'b1;
    step_chk(0, 0, 1, "R8");
    step_chk(0, 0, 2, "R8");
    for (int k = 0; k < 6; k++) step_chk(0, 1, k % 3, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule